// File: doc/BRIEF.md
# Paged External Data Memory Interface

This block sits between an 8-bit controller core and an external data memory of up to 16 MB. It keeps two 16-bit data pointers, each paired with its own page byte, plus a separate upper-address byte used by register-indirect accesses. One of the two pointers is active at a time. For every access, the block forms a 24-bit address from the active pointer and its page, or from the upper-address byte and a low byte supplied with the request. It then runs a single read or write strobe whose length is programmed in a control register.

The core issues an access on a valid/ready request channel. A request transfers on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the strobe ends, so the core is stalled for the whole stretched access. The request fields must be held stable while `req_valid` is high and `req_ready` is low. `done` pulses in the final strobe cycle and cannot be back-pressured. Read data is registered on that final clock and appears on `rd_data` from the following cycle until the next read completes.

Control pins are plain. A byte-wide register port loads and reads back the pointers, pages, upper-address byte and control register. Step inputs increment or decrement the active pointer. When auto-switch is enabled, the active pointer toggles after each pointer-based access, which suits copying between two memory regions.

Top module: `xmem_pager`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register readable on the register port to 0. While in reset and after it, `mem_rd`, `mem_wr`, `mem_wdata_oe` and `done` are low and `req_ready` is high.
- R2: Register codes on `reg_addr` are:
  - 0 = pointer 0 low byte, 1 = pointer 0 high byte, 2 = page 0.
  - 3 = pointer 1 low byte, 4 = pointer 1 high byte, 5 = page 1.
  - 6 = indirect upper byte, 7 = control.
  - Control bit 0 selects the active pointer, bit 1 enables auto-switch, bits 6:4 hold the stretch value, and the other bits read 0.
  - A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the addressed register combinationally.
- R3: A request with `req_indirect` high drives `mem_addr` = {8'h00, indirect upper byte, `req_lo`}.
- R4: A pointer-mode request (`req_indirect` low) drives `mem_addr` = {active page, active pointer high byte, active pointer low byte}.
- R5: Each access asserts exactly one strobe: `mem_wr` if `req_write` is high, otherwise `mem_rd`. `mem_wdata_oe` is high exactly while `mem_wr` is high, and `mem_wdata` then equals the request's `req_wdata`.
- R6: The strobe starts in the cycle after acceptance and lasts stretch+1 cycles (stretch 0 gives 1 cycle, 7 gives 8). `mem_addr` and `mem_wdata` stay constant across it.
- R7: `req_ready` is low in every strobe cycle and high otherwise. `done` is high only in the last strobe cycle. After a read, `rd_data` equals `mem_rdata` as sampled on the last strobe clock, from the next cycle on. A request held pending during an access is accepted only after that access ends.
- R8: A `step_en` cycle changes the active 16-bit pointer by +1, or by -1 when `step_down` is high, wrapping modulo 2^16. It leaves that pointer's page and the other pointer unchanged.
- R9: With auto-switch set, the select bit inverts at the end of each pointer-mode access. It does not change after an indirect access, nor when auto-switch is clear.
- R10: A register write to a pointer byte in the same cycle as `step_en` on that pointer wins: the written byte is loaded, the other byte keeps its value, and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register code |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of addressed register |
| step_en | input | 1 | Step the active pointer this cycle |
| step_down | input | 1 | Step direction: 1 decrement, 0 increment |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | Access is a write |
| req_indirect | input | 1 | Use register-indirect addressing |
| req_lo | input | 8 | Low address byte for indirect access |
| req_wdata | input | 8 | Write data |
| done | output | 1 | Last strobe cycle of an access |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 24 | External memory address |
| mem_wdata | output | 8 | Data to memory |
| mem_wdata_oe | output | 1 | Enable for external data bus drivers |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Data from memory |

## Verification
The bench measures the strobe at stretch values 0, 3 and 7. An off-by-one in the down-counter would make the strobe one clock too long or too short, or move `done` off the last strobe cycle. It steps pointers across the 8'hFF/8'h00 byte boundary and wraps 16'h0000 down to 16'hFFFF. A carry leaking into the page, or a step hitting the inactive pointer, shows up in the read-back. It holds a second request pending during a long access and checks that the address does not move early. It also alternates pointer, indirect and auto-switch-disabled accesses, which exposes a select bit that flips at the wrong time. Finally, it collides a pointer byte write with a step and checks that the write alone lands.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int STR_W = 3;
  localparam int CTL_SEL = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_STR_LSB = 4;

  typedef enum logic [2:0] {
    RA_P0_LO = 3'd0,
    RA_P0_HI = 3'd1,
    RA_P0_PG = 3'd2,
    RA_P1_LO = 3'd3,
    RA_P1_HI = 3'd4,
    RA_P1_PG = 3'd5,
    RA_IDX   = 3'd6,
    RA_CTRL  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/xmem_ptr_bank.sv
module xmem_ptr_bank
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  parameter bit DEC_EN = 1'b1,
  localparam int PW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             step_en,
  input  logic             step_down,
  input  logic             flip,
  output logic [PW-1:0]    act_ptr,
  output logic [DW-1:0]    act_page,
  output logic [DW-1:0]    idx_hi,
  output logic             auto_en,
  output logic [STR_W-1:0] stretch
);
  reg_addr_e wa, ra;
  assign wa = reg_addr_e'(wr_addr);
  assign ra = reg_addr_e'(rd_addr);

  logic [PW-1:0] ptr_q [2];
  logic [DW-1:0] page_q [2];
  logic          sel_q;
  logic          auto_q;
  logic [STR_W-1:0] str_q;
  logic [DW-1:0] idx_q;
  logic [PW-1:0] stepped;

  assign act_ptr  = ptr_q[sel_q];
  assign act_page = page_q[sel_q];
  assign idx_hi   = idx_q;
  assign auto_en  = auto_q;
  assign stretch  = str_q;

  generate
    if (DEC_EN) begin : g_updown
      assign stepped = step_down ? act_ptr - PW'(1) : act_ptr + PW'(1);
    end else begin : g_uponly
      assign stepped = act_ptr + PW'(1);
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < 2; i++) begin : g_ptr
      localparam reg_addr_e CODE_LO = reg_addr_e'(3 * i);
      localparam reg_addr_e CODE_HI = reg_addr_e'(3 * i + 1);
      localparam reg_addr_e CODE_PG = reg_addr_e'(3 * i + 2);
      logic hit_lo, hit_hi;
      assign hit_lo = wr_en && (wa == CODE_LO);
      assign hit_hi = wr_en && (wa == CODE_HI);

      always_ff @(posedge clk) begin
        if (rst) begin
          ptr_q[i] <= '0;
        end else if (hit_lo) begin
          ptr_q[i][DW-1:0] <= wr_data;
        end else if (hit_hi) begin
          ptr_q[i][PW-1:DW] <= wr_data;
        end else if (step_en && (sel_q == 1'(i))) begin
          ptr_q[i] <= stepped;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          page_q[i] <= '0;
        end else if (wr_en && (wa == CODE_PG)) begin
          page_q[i] <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      auto_q <= 1'b0;
      str_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (wr_en && (wa == RA_CTRL)) begin
        sel_q  <= wr_data[CTL_SEL];
        auto_q <= wr_data[CTL_AUTO];
        str_q  <= wr_data[CTL_STR_LSB +: STR_W];
      end else if (flip) begin
        sel_q <= ~sel_q;
      end
      if (wr_en && (wa == RA_IDX)) begin
        idx_q <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (ra)
      RA_P0_LO: rd_data = ptr_q[0][DW-1:0];
      RA_P0_HI: rd_data = ptr_q[0][PW-1:DW];
      RA_P0_PG: rd_data = page_q[0];
      RA_P1_LO: rd_data = ptr_q[1][DW-1:0];
      RA_P1_HI: rd_data = ptr_q[1][PW-1:DW];
      RA_P1_PG: rd_data = page_q[1];
      RA_IDX:   rd_data = idx_q;
      RA_CTRL: begin
        rd_data[CTL_SEL] = sel_q;
        rd_data[CTL_AUTO] = auto_q;
        rd_data[CTL_STR_LSB +: STR_W] = str_q;
      end
      default: rd_data = '0;
    endcase
  end

  // Pointers move only on a write or a step (R8)
  assert_ptr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !step_en) |=> ($stable(ptr_q[0]) && $stable(ptr_q[1])));

  // Select changes only on a control write or an auto-switch flip (R9)
  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wa == RA_CTRL) && !flip) |=> $stable(sel_q));

  // A flip without a control write inverts the select (R9)
  assert_sel_flip_R9: assert property (@(posedge clk) disable iff (rst)
    (flip && !(wr_en && wa == RA_CTRL)) |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/xmem_addr_sel.sv
module xmem_addr_sel #(
  parameter int DW = 8,
  localparam int PW = 2 * DW,
  localparam int AW = 3 * DW
) (
  input  logic          indirect,
  input  logic [PW-1:0] act_ptr,
  input  logic [DW-1:0] act_page,
  input  logic [DW-1:0] idx_hi,
  input  logic [DW-1:0] lo,
  output logic [AW-1:0] addr
);
  always_comb begin
    if (indirect) addr = {{DW{1'b0}}, idx_hi, lo};
    else          addr = {act_page, act_ptr};
  end
endmodule

// File: rtl/xmem_strobe_seq.sv
module xmem_strobe_seq
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 3 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_indirect,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdata_in,
  input  logic [STR_W-1:0] stretch,
  output logic             done,
  output logic             done_ptr,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_oe,
  output logic             mem_rd,
  output logic             mem_wr,
  input  logic [DW-1:0]    mem_rdata
);
  logic             active_q;
  logic [STR_W-1:0] cnt_q;
  logic             is_wr_q;
  logic             is_ind_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rd_q;
  logic             accept;
  logic             last;

  assign accept = req_valid && !active_q;
  assign last   = active_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      is_wr_q  <= 1'b0;
      is_ind_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_q     <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      cnt_q    <= stretch;
      is_wr_q  <= req_write;
      is_ind_q <= req_indirect;
      addr_q   <= addr_in;
      wdata_q  <= wdata_in;
    end else if (active_q) begin
      if (last) begin
        active_q <= 1'b0;
        if (!is_wr_q) rd_q <= mem_rdata;
      end else begin
        cnt_q <= cnt_q - STR_W'(1);
      end
    end
  end

  assign req_ready    = !active_q;
  assign done         = last;
  assign done_ptr     = last && !is_ind_q;
  assign rd_data      = rd_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_rd       = active_q && !is_wr_q;
  assign mem_wr       = active_q && is_wr_q;
  assign mem_wdata_oe = active_q && is_wr_q;

  // Never both strobes at once (R5)
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // Address and data hold across a running strobe (R6)
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !done) |=>
      ((mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));

  // Strobe ends right after done (R7)
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !(mem_rd || mem_wr));

  // Ready is low throughout the strobe (R7)
  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> !req_ready);
endmodule

// File: rtl/xmem_pager.sv
module xmem_pager
  import xmem_pkg::*;
#(
  parameter int DW = 8,
  parameter bit DEC_EN = 1'b1,
  localparam int PW = 2 * DW,
  localparam int AW = 3 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          step_en,
  input  logic          step_down,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_indirect,
  input  logic [DW-1:0] req_lo,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata
);
  logic [PW-1:0]    act_ptr;
  logic [DW-1:0]    act_page;
  logic [DW-1:0]    idx_hi;
  logic             auto_en;
  logic [STR_W-1:0] stretch;
  logic [AW-1:0]    req_addr;
  logic             done_ptr;
  logic             flip;

  assign flip = done_ptr && auto_en;

  xmem_ptr_bank #(.DW(DW), .DEC_EN(DEC_EN)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_we),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .rd_addr  (reg_addr),
    .rd_data  (reg_rdata),
    .step_en  (step_en),
    .step_down(step_down),
    .flip     (flip),
    .act_ptr  (act_ptr),
    .act_page (act_page),
    .idx_hi   (idx_hi),
    .auto_en  (auto_en),
    .stretch  (stretch)
  );

  xmem_addr_sel #(.DW(DW)) u_asel (
    .indirect(req_indirect),
    .act_ptr (act_ptr),
    .act_page(act_page),
    .idx_hi  (idx_hi),
    .lo      (req_lo),
    .addr    (req_addr)
  );

  xmem_strobe_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_indirect(req_indirect),
    .addr_in     (req_addr),
    .wdata_in    (req_wdata),
    .stretch     (stretch),
    .done        (done),
    .done_ptr    (done_ptr),
    .rd_data     (rd_data),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_wdata_oe(mem_wdata_oe),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_rdata   (mem_rdata)
  );

  // Data bus enable tracks the write strobe (R5)
  assert_oe_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wdata_oe == mem_wr);
endmodule

// File: tb/test_xmem_pager.sv
module test_xmem_pager;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, reg_we, step_en, step_down;
  logic req_valid, req_ready, req_write, req_indirect, done;
  logic mem_wdata_oe, mem_rd, mem_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, req_lo, req_wdata, rd_data, mem_wdata, mem_rdata;
  logic [23:0] mem_addr;

  function automatic logic [7:0] mdl(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign mem_rdata = mdl(mem_addr);

  xmem_pager i_xmem_pager (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_en(step_en),
    .step_down(step_down), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_indirect(req_indirect), .req_lo(req_lo),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rptr(input int i, output logic [15:0] v);
    logic [7:0] lo, hi;
    rreg(3'(3 * i), lo);
    rreg(3'(3 * i + 1), hi);
    v = {hi, lo};
  endtask

  task automatic step(input logic dn);
    @(negedge clk);
    step_en = 1'b1; step_down = dn;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic access(input logic wr, input logic ind, input logic [7:0] lo,
                        input logic [7:0] wd, input logic [23:0] exp_addr,
                        input int exp_len, input string tag);
    int n;
    @(negedge clk);
    chk({tag, " R7 ready idle"}, req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_indirect = ind; req_lo = lo; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while ((mem_rd || mem_wr) && n < 20) begin
      n++;
      chk({tag, " R3/R4 address"}, mem_addr, exp_addr);
      chk({tag, " R5 read strobe"}, mem_rd, !wr);
      chk({tag, " R5 write strobe"}, mem_wr, wr);
      chk({tag, " R5 data enable"}, mem_wdata_oe, wr);
      if (wr) chk({tag, " R5 write data"}, mem_wdata, wd);
      chk({tag, " R7 done position"}, done, (n == exp_len));
      chk({tag, " R7 ready low"}, req_ready, 0);
      @(negedge clk);
    end
    chk({tag, " R6 strobe width"}, n, exp_len);
    if (!wr) chk({tag, " R7 read data"}, rd_data, mdl(exp_addr));
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rd low", mem_rd, 0);
    chk("R1 wr low", mem_wr, 0);
    chk("R1 oe low", mem_wdata_oe, 0);
    chk("R1 done low", done, 0);
    chk("R1 ready high", req_ready, 1);
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), v);
      chk("R1 register cleared", v, 0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] v;
    for (int a = 0; a < 7; a++) begin
      wreg(3'(a), 8'(8'h31 + 8'(a * 17)));
    end
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), v);
      chk("R2 readback", v, 8'(8'h31 + 8'(a * 17)));
    end
    wreg(3'd7, 8'hFF);
    rreg(3'd7, v);
    chk("R2 control unused bits", v, 8'h73);
    wreg(3'd7, 8'h00);
  endtask

  task automatic t_pointer_modes;
    wreg(3'd0, 8'h34); wreg(3'd1, 8'h12); wreg(3'd2, 8'h9A);
    wreg(3'd3, 8'hCD); wreg(3'd4, 8'hAB); wreg(3'd5, 8'h5C);
    wreg(3'd7, 8'h00);
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h9A1234, 1, "ptr0 read");
    wreg(3'd7, 8'h01);
    access(1'b1, 1'b0, 8'h00, 8'hE7, 24'h5CABCD, 1, "ptr1 write");
  endtask

  task automatic t_indirect;
    wreg(3'd6, 8'h4F);
    access(1'b0, 1'b1, 8'h21, 8'h00, 24'h004F21, 1, "R3 indirect read");
    access(1'b1, 1'b1, 8'hFE, 8'h3C, 24'h004FFE, 1, "R3 indirect write");
  endtask

  task automatic t_stretch;
    wreg(3'd7, 8'h30);
    access(1'b1, 1'b0, 8'h00, 8'h96, 24'h9A1234, 4, "R6 stretch3 write");
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h9A1234, 4, "R6 stretch3 read");
    wreg(3'd7, 8'h70);
    access(1'b0, 1'b1, 8'h10, 8'h00, 24'h004F10, 8, "R6 stretch7 read");
    access(1'b1, 1'b0, 8'h00, 8'h69, 24'h9A1234, 8, "R6 stretch7 write");
    wreg(3'd7, 8'h00);
  endtask

  task automatic t_pending;
    wreg(3'd7, 8'h30);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_indirect = 1'b1; req_lo = 8'h11;
    @(negedge clk);
    req_lo = 8'h22;
    for (int k = 0; k < 4; k++) begin
      chk("R7 pending stalled", req_ready, 0);
      chk("R6 address held while pending", mem_addr, 24'h004F11);
      @(negedge clk);
    end
    chk("R7 gap cycle ready", req_ready, 1);
    chk("R7 gap cycle no strobe", mem_rd, 0);
    chk("R7 first read data", rd_data, mdl(24'h004F11));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 pending accepted", mem_rd, 1);
    chk("R3 pending address", mem_addr, 24'h004F22);
    repeat (4) @(negedge clk);
    chk("R7 second access over", mem_rd, 0);
    chk("R7 second read data", rd_data, mdl(24'h004F22));
    wreg(3'd7, 8'h00);
  endtask

  task automatic t_step;
    logic [15:0] p;
    logic [7:0] v;
    wreg(3'd7, 8'h00);
    wreg(3'd0, 8'hFF); wreg(3'd1, 8'h00); wreg(3'd2, 8'h44);
    wreg(3'd3, 8'hCD); wreg(3'd4, 8'hAB);
    step(1'b0);
    rptr(0, p); chk("R8 increment carry", p, 16'h0100);
    rreg(3'd2, v); chk("R8 page untouched", v, 8'h44);
    rptr(1, p); chk("R8 other pointer untouched", p, 16'hABCD);
    step(1'b1);
    rptr(0, p); chk("R8 decrement", p, 16'h00FF);
    wreg(3'd0, 8'h00);
    step(1'b1);
    rptr(0, p); chk("R8 wrap down", p, 16'hFFFF);
    rreg(3'd2, v); chk("R8 page untouched on wrap", v, 8'h44);
    wreg(3'd7, 8'h01);
    step(1'b0);
    rptr(1, p); chk("R8 step pointer 1", p, 16'hABCE);
    rptr(0, p); chk("R8 pointer 0 untouched", p, 16'hFFFF);
  endtask

  task automatic t_autosw;
    logic [7:0] v;
    wreg(3'd0, 8'h00); wreg(3'd1, 8'h01); wreg(3'd2, 8'h02);
    wreg(3'd3, 8'h00); wreg(3'd4, 8'h02); wreg(3'd5, 8'h03);
    wreg(3'd7, 8'h02);
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h020100, 1, "R9 auto first");
    rreg(3'd7, v); chk("R9 select flipped", v, 8'h03);
    access(1'b1, 1'b0, 8'h00, 8'h5A, 24'h030200, 1, "R9 auto second");
    rreg(3'd7, v); chk("R9 select flipped back", v, 8'h02);
    access(1'b0, 1'b1, 8'h07, 8'h00, 24'h004F07, 1, "R9 indirect");
    rreg(3'd7, v); chk("R9 no flip on indirect", v, 8'h02);
    wreg(3'd7, 8'h00);
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h020100, 1, "R9 auto off");
    rreg(3'd7, v); chk("R9 no flip when disabled", v, 8'h00);
  endtask

  task automatic t_priority;
    logic [15:0] p;
    wreg(3'd7, 8'h00);
    wreg(3'd0, 8'hFF); wreg(3'd1, 8'h12);
    @(negedge clk);
    step_en = 1'b1; step_down = 1'b0;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h40;
    @(negedge clk);
    step_en = 1'b0; reg_we = 1'b0;
    rptr(0, p); chk("R10 write beats step", p, 16'h1240);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
  endtask

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    step_en = 1'b0; step_down = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_indirect = 1'b0; req_lo = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready during reset", req_ready, 1);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_pointer_modes();
    t_indirect();
    t_stretch();
    t_pending();
    t_step();
    t_autosw();
    t_priority();
    t_rereset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule